// File: doc/BRIEF.md
# Supply Lockout and Start-Up Sequencer

This block brings a current-sensing front end up from a cold supply. Two comparator bits describe the supply: one reports that it is above the trip level, and the other reports that it is above the trip level plus a hysteresis margin. Both bits are synchronized and debounced before the control logic sees them. While the supply is low, the block holds the front end locked out. The sensor outputs sit at their minimum and the timing inputs are ignored.

Leaving lockout requires the upper (hysteresis) comparator. Re-entering lockout happens whenever the lower comparator drops, from any phase. After lockout the block runs a calibration window of fixed length, and the timing inputs are still ignored during it. It then enables the timing inputs and waits for one complete integrator reset request, a rise followed by a fall, before it declares the outputs valid. Calibration is repeated only after another pass through lockout. Nothing in steady operation, such as a change in temperature, can restart it.

Top module: `supply_start_seq`

## Requirements
- R1: While reset is applied, `lockout` is 1 and `cal_busy`, `inputs_enable` and `outputs_valid` are 0.
- R2: A comparator level change is acted on only after the synchronized value has differed from the filtered value for DEB_LEN consecutive clocks. A pulse shorter than that on either comparator changes no output.
- R3: Lockout is left only when both filtered comparators are 1. With only the trip comparator at 1 (supply inside the hysteresis band), `lockout` stays 1.
- R4: Leaving lockout enters calibration. `cal_busy` is 1 for exactly CAL_CYCLES clocks, then drops and `inputs_enable` rises.
- R5: `rst_req` has no effect in lockout or calibration. `outputs_valid` stays 0 and the calibration length is unchanged.
- R6: After calibration, `outputs_valid` is 0 until `rst_req` has been seen at 1 and then at 0. It rises on the clock edge that samples `rst_req` at 0 after the request. A request already high when the inputs are enabled counts as the first request.
- R7: A filtered trip comparator at 0 returns the block to lockout from calibration, waiting or running. The hysteresis comparator falling alone does not.
- R8: Once running, the block stays running whatever `rst_req` does, and `cal_busy` never rises again without lockout in between.
- R9: Exactly one of `lockout`, `cal_busy`, `inputs_enable` is 1, and `outputs_valid` implies `inputs_enable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sup_above_trip | input | 1 | Asynchronous comparator: supply above the trip level |
| sup_above_hyst | input | 1 | Asynchronous comparator: supply above trip level plus hysteresis |
| rst_req | input | 1 | Synchronous integrator reset request from the reset decode |
| lockout | output | 1 | Front end held off, outputs at minimum |
| cal_busy | output | 1 | Self-calibration window active |
| inputs_enable | output | 1 | Timing inputs honoured |
| outputs_valid | output | 1 | First reset has completed, measurements may be used |

## Verification
The assertions assume that `rst_req` is already synchronous to `clk` and that the comparator bits are consistent: the hysteresis bit is never high while the trip bit is low for longer than the debounce window. The stimulus only moves `rst_req` on the falling clock edge. It raises the hysteresis bit only after the trip bit and lowers it first. Comparator glitches are kept deliberately shorter than DEB_LEN, so they probe the filter without breaking that ordering.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [1:0] {
    PH_LOCK = 2'd0,
    PH_CAL  = 2'd1,
    PH_WAIT = 2'd2,
    PH_RUN  = 2'd3
  } phase_e;
endpackage

// File: rtl/cmp_filter.sv
module cmp_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_LEN     = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic filt
);
  localparam int CW = (DEB_LEN < 2) ? 1 : $clog2(DEB_LEN);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q, cnt_d;
  logic                   filt_q, filt_d;
  logic                   differs;

  // synchronizer chain
  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= raw;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
      end
    end
  endgenerate

  assign differs = sync_q[SYNC_STAGES-1] ^ filt_q;

  always_comb begin
    cnt_d  = '0;
    filt_d = filt_q;
    if (differs) begin
      if (cnt_q == CW'(DEB_LEN-1)) filt_d = sync_q[SYNC_STAGES-1];
      else                         cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      filt_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      filt_q <= filt_d;
    end
  end

  assign filt = filt_q;
endmodule

// File: rtl/cal_timer.sv
module cal_timer #(
  parameter int CAL_CYCLES = 32000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int TW = $clog2(CAL_CYCLES + 1);

  logic [TW-1:0] cnt_q, cnt_d;

  assign done = run && (cnt_q == TW'(CAL_CYCLES - 1));

  always_comb begin
    if (run && !done) cnt_d = cnt_q + 1'b1;
    else              cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   trip_ok,
  input  logic   hyst_ok,
  input  logic   cal_done,
  input  logic   req,
  output phase_e phase
);
  phase_e phase_q, phase_d;
  logic   armed_q, armed_d;

  always_comb begin
    phase_d = phase_q;
    if (!trip_ok) begin
      phase_d = PH_LOCK;
    end else begin
      unique case (phase_q)
        PH_LOCK: if (hyst_ok)            phase_d = PH_CAL;
        PH_CAL:  if (cal_done)           phase_d = PH_WAIT;
        PH_WAIT: if (armed_q && !req)    phase_d = PH_RUN;
        PH_RUN:                          phase_d = PH_RUN;
        default:                         phase_d = PH_LOCK;
      endcase
    end
    armed_d = (phase_q == PH_WAIT && phase_d == PH_WAIT) ? (armed_q | req) : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_LOCK;
      armed_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      armed_q <= armed_d;
    end
  end

  assign phase = phase_q;
endmodule

// File: rtl/supply_start_seq.sv
module supply_start_seq
  import seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_LEN     = 4,
  parameter int CAL_CYCLES  = 32000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_above_trip,
  input  logic sup_above_hyst,
  input  logic rst_req,
  output logic lockout,
  output logic cal_busy,
  output logic inputs_enable,
  output logic outputs_valid
);
  localparam int NCMP = 2;

  logic [1:0]      rst_pipe;
  logic            rst_sync_n;
  logic [NCMP-1:0] cmp_raw, cmp_filt;
  logic            cal_done;
  phase_e          phase;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign cmp_raw = {sup_above_hyst, sup_above_trip};

  generate
    for (genvar gi = 0; gi < NCMP; gi++) begin : g_cmp
      cmp_filter #(.SYNC_STAGES(SYNC_STAGES), .DEB_LEN(DEB_LEN)) u_filt (
        .clk  (clk),
        .rst_n(rst_sync_n),
        .raw  (cmp_raw[gi]),
        .filt (cmp_filt[gi])
      );
    end
  endgenerate

  cal_timer #(.CAL_CYCLES(CAL_CYCLES)) u_timer (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .run  (phase == PH_CAL),
    .done (cal_done)
  );

  seq_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .trip_ok (cmp_filt[0]),
    .hyst_ok (cmp_filt[1]),
    .cal_done(cal_done),
    .req     (rst_req),
    .phase   (phase)
  );

  assign lockout       = (phase == PH_LOCK);
  assign cal_busy      = (phase == PH_CAL);
  assign inputs_enable = (phase == PH_WAIT) || (phase == PH_RUN);
  assign outputs_valid = (phase == PH_RUN);
endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int CAL_CYCLES = 32000
) (
  input logic clk,
  input logic rst_n,
  input logic rst_req,
  input logic lockout,
  input logic cal_busy,
  input logic inputs_enable,
  input logic outputs_valid
);
  localparam int RW = $clog2(CAL_CYCLES + 2);

  logic [RW-1:0] cal_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cal_run <= '0;
    else if (cal_busy) cal_run <= cal_run + 1'b1;
    else               cal_run <= '0;
  end

  assert_one_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({lockout, cal_busy, inputs_enable}) == 1);

  assert_valid_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    outputs_valid |-> inputs_enable);

  assert_cal_after_lockout_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_busy) |-> $past(lockout));

  assert_lockout_exit_to_cal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lockout) |-> cal_busy);

  assert_cal_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cal_busy) && inputs_enable) |-> (cal_run == RW'(CAL_CYCLES)));

  assert_valid_after_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(outputs_valid) |-> ($past(inputs_enable) && !$past(rst_req)));

  assert_enable_drop_to_lockout_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(inputs_enable) |-> lockout);

  assert_run_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (outputs_valid && !$stable(rst_req)) |=> (outputs_valid || lockout));
endmodule

bind supply_start_seq seq_checker #(.CAL_CYCLES(CAL_CYCLES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rst_req      (rst_req),
  .lockout      (lockout),
  .cal_busy     (cal_busy),
  .inputs_enable(inputs_enable),
  .outputs_valid(outputs_valid)
);

// File: tb/supply_start_seq_test.sv
module supply_start_seq_test;
  localparam int DEB = 4;
  localparam int CAL = 40;

  logic clk = 1'b0;
  logic rst_n;
  logic trip, hyst, req;
  logic lockout, cal_busy, inputs_enable, outputs_valid;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_tag = "R1";
  bit cmp_on = 0;

  always #2.5 clk = ~clk;

  supply_start_seq #(.SYNC_STAGES(2), .DEB_LEN(DEB), .CAL_CYCLES(CAL)) uut (
    .clk(clk), .rst_n(rst_n), .sup_above_trip(trip), .sup_above_hyst(hyst),
    .rst_req(req), .lockout(lockout), .cal_busy(cal_busy),
    .inputs_enable(inputs_enable), .outputs_valid(outputs_valid)
  );

  // behavioural reference: phase 0 lock, 1 cal, 2 wait, 3 run
  bit m_rs1, m_rs2, m_armed;
  bit m_s1[2], m_s2[2], m_filt[2];
  int m_dc[2];
  int m_phase, m_cal;

  task automatic model_clear();
    m_armed = 0; m_phase = 0; m_cal = 0;
    for (int i = 0; i < 2; i++) begin
      m_s1[i] = 0; m_s2[i] = 0; m_filt[i] = 0; m_dc[i] = 0;
    end
  endtask

  task automatic model_step(bit in_trip, bit in_hyst, bit in_req);
    int nxt;
    bit done;
    bit ins[2];
    ins[0] = in_trip; ins[1] = in_hyst;
    done = (m_phase == 1) && (m_cal == CAL - 1);
    nxt = m_phase;
    if (!m_filt[0]) nxt = 0;
    else if (m_phase == 0 && m_filt[1]) nxt = 1;
    else if (m_phase == 1 && done) nxt = 2;
    else if (m_phase == 2 && m_armed && !in_req) nxt = 3;
    m_armed = (m_phase == 2 && nxt == 2) ? (m_armed | in_req) : 0;
    m_cal = (m_phase == 1 && !done) ? m_cal + 1 : 0;
    m_phase = nxt;
    for (int i = 0; i < 2; i++) begin
      if (m_s2[i] == m_filt[i]) m_dc[i] = 0;
      else if (m_dc[i] == DEB - 1) begin m_filt[i] = m_s2[i]; m_dc[i] = 0; end
      else m_dc[i]++;
      m_s2[i] = m_s1[i];
      m_s1[i] = ins[i];
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs1 = 0; m_rs2 = 0; model_clear();
    end else begin
      if (m_rs2) model_step(trip, hyst, req);
      else       model_clear();
      m_rs2 = m_rs1; m_rs1 = 1;
      cmp_on = 1;
    end
  end

  function automatic logic [3:0] exp_out();
    return {m_phase == 0, m_phase == 1, m_phase >= 2, m_phase == 3};
  endfunction

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {lockout,cal_busy,inputs_enable,outputs_valid} actual %b expected %b at %0t",
               tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && cmp_on)
      check(cur_tag, {lockout, cal_busy, inputs_enable, outputs_valid}, exp_out());
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_cal_start();
    for (int g = 0; g < 60 && !cal_busy; g++) @(negedge clk);
  endtask

  initial begin
    int len;
    rst_n = 1'b0; trip = 1'b0; hyst = 1'b0; req = 1'b0;
    cyc(3);
    cur_tag = "R1";
    check("R1 reset state", {lockout, cal_busy, inputs_enable, outputs_valid}, 4'b1000);
    rst_n = 1'b1;
    cyc(4);
    check("R1 after release", {lockout, cal_busy, inputs_enable, outputs_valid}, 4'b1000);

    cur_tag = "R5";
    req = 1'b1; cyc(3); req = 1'b0; cyc(3);
    check("R5 request in lockout", {lockout, outputs_valid}, 2'b10);

    cur_tag = "R3";
    trip = 1'b1; cyc(30);
    check("R3 inside hysteresis band", {lockout, cal_busy}, 2'b10);

    cur_tag = "R2";
    hyst = 1'b1; cyc(DEB - 2); hyst = 1'b0; cyc(20);
    check("R2 short hysteresis pulse", {lockout, cal_busy}, 2'b10);

    cur_tag = "R4";
    hyst = 1'b1;
    wait_cal_start();
    len = 0;
    while (cal_busy && len < 200) begin
      req = ((len % 5) == 1) && (len < CAL - 4);
      len++;
      @(negedge clk);
    end
    req = 1'b0;
    checks++;
    if (len != CAL) begin
      errors++;
      $display("FAIL R4 calibration length: actual %0d expected %0d", len, CAL);
    end
    check("R5 requests during cal ignored", {inputs_enable, outputs_valid}, 2'b10);

    cur_tag = "R6";
    cyc(5);
    check("R6 no request yet", {inputs_enable, outputs_valid}, 2'b10);
    req = 1'b1; cyc(3);
    check("R6 request held", outputs_valid, 1'b0);
    req = 1'b0; cyc(1);
    check("R6 valid after request release", outputs_valid, 1'b1);

    cur_tag = "R8";
    for (int k = 0; k < 3; k++) begin req = 1'b1; cyc(2); req = 1'b0; cyc(3); end
    check("R8 stays running", {cal_busy, outputs_valid}, 2'b01);

    cur_tag = "R7";
    hyst = 1'b0; cyc(20);
    check("R7 hysteresis drop alone", outputs_valid, 1'b1);
    cur_tag = "R2";
    trip = 1'b0; cyc(DEB - 2); trip = 1'b1; cyc(15);
    check("R2 short trip dip", outputs_valid, 1'b1);
    cur_tag = "R7";
    trip = 1'b0; cyc(15);
    check("R7 trip drop from run", lockout, 1'b1);

    trip = 1'b1; cyc(5); hyst = 1'b1;
    wait_cal_start();
    cyc(10);
    hyst = 1'b0; trip = 1'b0; cyc(15);
    check("R7 trip drop during cal", {lockout, cal_busy}, 2'b10);

    cur_tag = "R6";
    trip = 1'b1; cyc(5); hyst = 1'b1; req = 1'b1;
    wait_cal_start();
    for (int g = 0; g < 200 && cal_busy; g++) @(negedge clk);
    cyc(2);
    check("R6 request held across cal end", {inputs_enable, outputs_valid}, 2'b10);
    req = 1'b0; cyc(1);
    check("R6 held request counts as first", outputs_valid, 1'b1);
    cyc(5);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule